// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block carries out one data-processing operation per transfer of a processor datapath: addition and subtraction in plain, carry-chained and operand-swapped forms, the bitwise AND, OR, bit-clear and move-inverted operations, and two flag-only operations, a bit test and a compare. It receives a first operand from the register file, a second operand that an external shifter has already prepared (along with that shifter's carry-out), and the current carry and overflow flags. It returns a result word, a write strobe for the destination register, new N, Z, C and V values and a strobe that says whether the flags are to be updated.

Operations enter on a valid/ready input channel and leave on a valid/ready output channel, through one register stage. The upstream side may present an operation whenever it likes and must hold it until `in_ready` is high at a clock edge. The downstream side may hold `out_ready` low for any number of cycles. The block then keeps every output unchanged and accepts nothing new until the held result leaves. When `out_ready` is high, a new operation is accepted in the same cycle that the previous result leaves, so the block sustains one operation per cycle.

Opcode values (`in_op`): 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 reverse subtract, 5 reverse subtract-with-carry, 6 AND, 7 OR, 8 bit-clear, 9 move-inverted, 10 test, 11 compare, 12 to 15 reserved.

Top module: `dp_alu`

## Requirements
- R1: `in_ready` is high exactly when no result is held or `out_ready` is high. While `out_valid` is high and `out_ready` is low, every output holds its value into the next cycle. After reset, `out_valid` is low and `in_ready` is high.
- R2: An operation accepted at a clock edge (`in_valid` and `in_ready` high) shows its outputs, with `out_valid` high, from that edge until it is taken. Results leave in acceptance order.
- R3: Add (0) gives opa+opb. Add-with-carry (1) gives opa+opb+`in_carry`. C is the unsigned carry out of bit 31.
- R4: Subtract (2) gives opa−opb. Subtract-with-carry (3) gives opa−opb−(1−`in_carry`). C is 1 when no borrow occurs, meaning opa ≥ opb plus the borrow-in taken as unsigned values, and 0 otherwise.
- R5: Reverse subtract (4) gives opb−opa. Reverse subtract-with-carry (5) gives opb−opa−(1−`in_carry`). C is the no-borrow value of that swapped subtraction.
- R6: For opcodes 0 to 5 and 11, V is 1 exactly when the signed two's-complement result of the operation as performed falls outside the 32-bit range. N is bit 31 of the result, and Z is 1 when the result is all zeros.
- R7: AND (6) gives opa&opb. OR (7) gives opa|opb. Bit-clear (8) gives opa with every bit cleared where opb has a 1.
- R8: Move-inverted (9) gives the bitwise NOT of opb, so an opb of 4 gives 0xFFFFFFFB and an opb of 0 gives 0xFFFFFFFF. opa is ignored.
- R9: For opcodes 6 to 10, C equals `in_shift_carry`, V equals `in_ovf`, N is bit 31 of the result, and Z is 1 when the result is zero.
- R10: Test (10) places opa&opb on `out_result`, sets flags from it as in R9, drives `out_write` low and `out_flag_en` high whatever `in_set_flags` is.
- R11: Compare (11) places opa−opb on `out_result`, with flags as for subtract. It drives `out_write` low and `out_flag_en` high whatever `in_set_flags` is.
- R12: For opcodes 0 to 9, `out_write` is 1 and `out_flag_en` equals `in_set_flags`. The flag outputs carry the computed values even when `out_flag_en` is 0.
- R13: Reserved opcodes 12 to 15 give a result of 0, N=0, Z=1, C=`in_carry`, V=`in_ovf`, with `out_write` and `out_flag_en` both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_op | input | 4 | Opcode |
| in_set_flags | input | 1 | Request flag update for opcodes 0 to 9 |
| in_opa | input | 32 | First operand (register value) |
| in_opb | input | 32 | Second operand (shifted register or immediate) |
| in_shift_carry | input | 1 | Carry-out from the external shifter |
| in_carry | input | 1 | Current C flag |
| in_ovf | input | 1 | Current V flag |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Result word |
| out_write | output | 1 | Destination register write strobe |
| out_flag_en | output | 1 | Flag update strobe |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_c | output | 1 | Carry flag |
| out_v | output | 1 | Overflow flag |

## Verification
Every result, its write strobe and its four flags are due together, one clock edge after acceptance, and they stay on the outputs for as long as the consumer stalls. The bench changes its inputs and `out_ready` only after a falling edge and samples a little later in that half-cycle. A result is compared against the expected value at the head of the queue only when `out_valid` and `out_ready` are both high at that sample point, so the comparison always falls in the cycle when the transfer happens. A stalled result is compared with its own snapshot from the previous cycle. A separate directed check confirms that the result shows one edge after acceptance.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_RSB  = 4'd4,
    OP_RSC  = 4'd5,
    OP_AND  = 4'd6,
    OP_ORR  = 4'd7,
    OP_BIC  = 4'd8,
    OP_MVN  = 4'd9,
    OP_TST  = 4'd10,
    OP_CMP  = 4'd11,
    OP_RV12 = 4'd12,
    OP_RV13 = 4'd13,
    OP_RV14 = 4'd14,
    OP_RV15 = 4'd15
  } alu_op_e;

  function automatic logic op_is_arith(alu_op_e op);
    return (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB, OP_RSC, OP_CMP});
  endfunction

  function automatic logic op_is_logic(alu_op_e op);
    return (op inside {OP_AND, OP_ORR, OP_BIC, OP_MVN, OP_TST});
  endfunction

endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x_op;
  logic [WIDTH-1:0] y_op;
  logic             cin;
  logic [WIDTH:0]   full;

  // Steer operands so that every form becomes x + y + cin.
  always_comb begin
    x_op = opa;
    y_op = opb;
    cin  = 1'b0;
    unique case (op)
      OP_ADC:         cin = carry_in;
      OP_SUB, OP_CMP: begin y_op = ~opb; cin = 1'b1; end
      OP_SBC:         begin y_op = ~opb; cin = carry_in; end
      OP_RSB:         begin x_op = opb; y_op = ~opa; cin = 1'b1; end
      OP_RSC:         begin x_op = opb; y_op = ~opa; cin = carry_in; end
      default:        ;
    endcase
  end

  assign full = {1'b0, x_op} + {1'b0, y_op} + {{WIDTH{1'b0}}, cin};
  assign sum  = full[MSB:0];
  assign cout = full[WIDTH];
  assign ovf  = (x_op[MSB] == y_op[MSB]) && (sum[MSB] != x_op[MSB]);

  // A plain subtract must report no-borrow exactly when opa >= opb.
  always_comb begin
    if (op == OP_SUB && !$isunknown({opa, opb})) begin
      AST_SUB_NO_BORROW: assert (cout == (opa >= opb)); // R4
    end
  end

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] res
);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: res = opa & opb;
      OP_ORR:         res = opa | opb;
      OP_BIC:         res = opa & ~opb;
      OP_MVN:         res = ~opb;
      default:        res = '0;
    endcase
  end

  // Bit-clear leaves no bit set where the mask is set.
  always_comb begin
    if (op == OP_BIC && !$isunknown({opa, opb})) begin
      AST_BIC_MASKED: assert ((res & opb) == '0); // R7
    end
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic             in_set_flags,
  input  logic [WIDTH-1:0] in_opa,
  input  logic [WIDTH-1:0] in_opb,
  input  logic             in_shift_carry,
  input  logic             in_carry,
  input  logic             in_ovf,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic             out_write,
  output logic             out_flag_en,
  output logic             out_n,
  output logic             out_z,
  output logic             out_c,
  output logic             out_v
);

  localparam int MSB = WIDTH - 1;

  // Input register stage
  logic             held_q;
  alu_op_e          op_q;
  logic             set_q;
  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] b_q;
  logic             shc_q;
  logic             c_q;
  logic             v_q;
  logic             take;

  assign in_ready = !held_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else if (in_ready) begin
      held_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      op_q  <= alu_op_e'(in_op);
      set_q <= in_set_flags;
      a_q   <= in_opa;
      b_q   <= in_opb;
      shc_q <= in_shift_carry;
      c_q   <= in_carry;
      v_q   <= in_ovf;
    end
  end

  // Datapath
  logic [WIDTH-1:0] sum;
  logic             cout;
  logic             ovf;
  logic [WIDTH-1:0] lres;

  dp_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .op       (op_q),
    .opa      (a_q),
    .opb      (b_q),
    .carry_in (c_q),
    .sum      (sum),
    .cout     (cout),
    .ovf      (ovf)
  );

  dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op  (op_q),
    .opa (a_q),
    .opb (b_q),
    .res (lres)
  );

  logic arith;
  logic logic_op;

  assign arith    = op_is_arith(op_q);
  assign logic_op = op_is_logic(op_q);

  always_comb begin
    if (arith) begin
      out_result = sum;
      out_c      = cout;
      out_v      = ovf;
    end else if (logic_op) begin
      out_result = lres;
      out_c      = shc_q;
      out_v      = v_q;
    end else begin
      out_result = '0;
      out_c      = c_q;
      out_v      = v_q;
    end
    out_n = out_result[MSB];
    out_z = (out_result == '0);
  end

  always_comb begin
    unique case (op_q)
      OP_TST, OP_CMP:                   begin out_write = 1'b0; out_flag_en = 1'b1;  end
      OP_RV12, OP_RV13, OP_RV14, OP_RV15: begin out_write = 1'b0; out_flag_en = 1'b0;  end
      default:                          begin out_write = 1'b1; out_flag_en = set_q; end
    endcase
  end

  assign out_valid = held_q;

  // Assertions
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable({out_n, out_z, out_c, out_v, out_write, out_flag_en})); // R1

  AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R2

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q == OP_CMP |-> !out_write && out_flag_en && out_z == (a_q == b_q)); // R11

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && op_q[3:2] == 2'b11 |-> !out_write && !out_flag_en && out_z); // R13

endmodule

// File: tb/dp_alu_tb.sv
module dp_alu_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic        in_set_flags = 1'b0;
  logic [31:0] in_opa = '0;
  logic [31:0] in_opb = '0;
  logic        in_shift_carry = 1'b0;
  logic        in_carry = 1'b0;
  logic        in_ovf = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_write;
  logic        out_flag_en;
  logic        out_n, out_z, out_c, out_v;

  always #4 clk = ~clk;

  dp_alu u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_set_flags(in_set_flags),
    .in_opa(in_opa), .in_opb(in_opb),
    .in_shift_carry(in_shift_carry), .in_carry(in_carry), .in_ovf(in_ovf),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_write(out_write), .out_flag_en(out_flag_en),
    .out_n(out_n), .out_z(out_z), .out_c(out_c), .out_v(out_v)
  );

  typedef struct {
    logic [3:0]  op;
    logic [31:0] res;
    logic [3:0]  nzcv;
    logic        wr;
    logic        fe;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int ready_mode = 0;
  int cyc = 0;
  logic done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [3:0] op, input logic s, input logic [31:0] a,
                                 input logic [31:0] b, input logic shc, input logic c, input logic v);
    exp_t e;
    longint sv;
    logic [32:0] u;
    logic bor;
    logic cf, vf;
    e.op = op;
    bor = !c;
    cf = c; vf = v; e.res = '0;
    case (op)
      4'd0, 4'd1: begin
        u = {1'b0, a} + {1'b0, b} + ((op == 4'd1) ? {32'd0, c} : 33'd0);
        e.res = u[31:0]; cf = u[32];
        sv = longint'($signed(a)) + longint'($signed(b)) + ((op == 4'd1) ? longint'(c) : 0);
        vf = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
      4'd2, 4'd3, 4'd11: begin
        if (op != 4'd3) bor = 1'b0;
        e.res = a - b - {31'd0, bor};
        cf = ({1'b0, a} >= {1'b0, b} + {32'd0, bor});
        sv = longint'($signed(a)) - longint'($signed(b)) - longint'(bor);
        vf = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
      4'd4, 4'd5: begin
        if (op != 4'd5) bor = 1'b0;
        e.res = b - a - {31'd0, bor};
        cf = ({1'b0, b} >= {1'b0, a} + {32'd0, bor});
        sv = longint'($signed(b)) - longint'($signed(a)) - longint'(bor);
        vf = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
      4'd6, 4'd10: begin e.res = a & b;  cf = shc; end
      4'd7:        begin e.res = a | b;  cf = shc; end
      4'd8:        begin e.res = a & ~b; cf = shc; end
      4'd9:        begin e.res = ~b;     cf = shc; end
      default:     ;
    endcase
    e.nzcv = {e.res[31], e.res == 32'd0, cf, vf};
    e.wr = (op <= 4'd9);
    e.fe = (op <= 4'd9) ? s : (op <= 4'd11);
    return e;
  endfunction

  function automatic string res_tag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd7, 4'd8: return "R7";
      4'd9: return "R8";
      4'd10: return "R10";
      4'd11: return "R11";
      default: return "R13";
    endcase
  endfunction

  function automatic logic next_ready();
    case (ready_mode)
      0: return 1'b1;
      1: return (cyc % 3) != 0;
      default: return (cyc % 5) == 0;
    endcase
  endfunction

  // Driver
  task automatic send(input logic [3:0] op, input logic s, input logic [31:0] a, input logic [31:0] b,
                      input logic shc, input logic c, input logic v, input bit lat_chk);
    bit got = 0;
    logic rdy;
    @(negedge clk); #2;
    in_valid = 1'b1; in_op = op; in_set_flags = s; in_opa = a; in_opb = b;
    in_shift_carry = shc; in_carry = c; in_ovf = v;
    while (!got) begin
      #1 rdy = in_ready;
      @(posedge clk);
      if (rdy) got = 1;
      else begin @(negedge clk); #2; end
    end
    q.push_back(model(op, s, a, b, shc, c, v));
    #1 in_valid = 1'b0;
    if (lat_chk) begin
      @(negedge clk); #3;
      check(out_valid === 1'b1, "R2 out_valid one edge after accept", {63'd0, out_valid}, 64'd1);
    end
  endtask

  // Monitor / scoreboard
  logic        stalled = 1'b0;
  logic [31:0] snap_res;
  logic [5:0]  snap_fl;

  initial begin
    forever begin
      @(negedge clk);
      #1 out_ready = next_ready();
      #1;
      if (rst_n) begin
        if (stalled && out_valid)
          check(out_result === snap_res && {out_n, out_z, out_c, out_v, out_write, out_flag_en} === snap_fl,
                "R1 outputs held during stall", {out_result, 26'd0, out_n, out_z, out_c, out_v, out_write, out_flag_en},
                {snap_res, 26'd0, snap_fl});
        stalled = 1'b0;
        if (out_valid) check(in_ready === out_ready, "R1 in_ready follows out_ready while full",
                             {63'd0, in_ready}, {63'd0, out_ready});
        if (out_valid && !out_ready) begin
          stalled = 1'b1;
          snap_res = out_result;
          snap_fl = {out_n, out_z, out_c, out_v, out_write, out_flag_en};
        end
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            check(1'b0, "R2 result with nothing outstanding", 64'd1, 64'd0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(out_result === e.res, res_tag(e.op), {32'd0, out_result}, {32'd0, e.res});
            check({out_n, out_z, out_c, out_v} === e.nzcv,
                  (e.op <= 4'd5 || e.op == 4'd11) ? "R6 flags" : (e.op <= 4'd10 ? "R9 flags" : "R13 flags"),
                  {60'd0, out_n, out_z, out_c, out_v}, {60'd0, e.nzcv});
            check({out_write, out_flag_en} === {e.wr, e.fe},
                  (e.op <= 4'd9) ? "R12 strobes" : res_tag(e.op),
                  {62'd0, out_write, out_flag_en}, {62'd0, e.wr, e.fe});
          end
        end
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired with %0d results outstanding", q.size());
      summary();
      $finish;
    end
  end

  // Stimulus
  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #3;
    check(out_valid === 1'b0, "R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    check(in_ready === 1'b1, "R1 reset in_ready", {63'd0, in_ready}, 64'd1);

    ready_mode = 0;
    send(4'd0, 1, 32'd5, 32'd7, 0, 0, 0, 1);                      // R3
    send(4'd1, 1, 32'hFFFF_FFFF, 32'd0, 0, 1, 0, 0);               // R3 carry out, Z
    send(4'd0, 1, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, 0);               // R6 overflow
    send(4'd2, 1, 32'd9, 32'd9, 0, 0, 0, 0);                       // R4 equal
    send(4'd2, 1, 32'd1, 32'd2, 0, 1, 0, 0);                       // R4 borrow
    send(4'd3, 1, 32'd10, 32'd3, 0, 0, 0, 0);                      // R4 borrow-in
    send(4'd2, 1, 32'h8000_0000, 32'd1, 0, 0, 0, 0);               // R6 overflow
    send(4'd4, 1, 32'd6, 32'd256, 0, 0, 0, 0);                     // R5
    send(4'd5, 1, 32'd6, 32'd6, 0, 0, 0, 0);                       // R5 borrow-in
    send(4'd6, 1, 32'hF0F0_F0F0, 32'hFF00_FF00, 1, 0, 1, 0);       // R7 R9
    send(4'd7, 0, 32'h0000_0000, 32'h0000_0003, 0, 1, 0, 0);       // R7 R12
    send(4'd8, 1, 32'hFFFF_FFFF, 32'h0000_000B, 1, 1, 0, 0);       // R7 bit-clear
    send(4'd9, 1, 32'h1234_5678, 32'd4, 0, 0, 1, 0);               // R8
    send(4'd9, 1, 32'hDEAD_BEEF, 32'd0, 1, 0, 0, 0);               // R8
    send(4'd10, 0, 32'h0000_0001, 32'h0000_0002, 1, 0, 1, 0);      // R10 Z set
    send(4'd10, 0, 32'h8000_0001, 32'h8000_0000, 0, 1, 0, 0);      // R10 N set
    send(4'd11, 0, 32'd3, 32'd3, 0, 0, 0, 0);                      // R11
    send(4'd11, 0, 32'd2, 32'd3, 0, 1, 1, 0);                      // R11 borrow
    send(4'd0, 0, 32'd1, 32'd1, 0, 0, 0, 0);                       // R12 no flag update
    for (int k = 12; k < 16; k++)
      send(4'(k), 1, 32'hAAAA_5555, 32'h1234_0000, 0, k[0], k[1], 0); // R13

    r = 32'h1357_9BDF;
    for (int m = 1; m < 3; m++) begin
      ready_mode = m;
      for (int i = 0; i < 120; i++) begin
        logic [31:0] a, b;
        r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5); a = r;
        r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5); b = r;
        send(4'(r[3:0]), r[4], a, (r[9:8] == 2'd0) ? a : b, r[5], r[6], r[7], 0);
      end
    end

    ready_mode = 0;
    repeat (20) @(posedge clk);
    check(q.size() == 0, "R2 all results delivered", {32'd0, 32'(q.size())}, 64'd0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule